// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns a 32-bit instruction word of a small load/store instruction set into the control signals a single-cycle datapath needs. It recognises two register-to-register operations (add and subtract), a logical OR with an immediate, a word load, a word store, a branch taken on equality and an absolute jump.

Decoding happens in two levels. A main decoder looks only at the 6-bit opcode in bits 31:26. It produces the steering and enable signals and a 3-bit ALU group code. A local ALU decoder then combines that group code with the 6-bit function field in bits 5:0 to choose the final ALU operation. The block is purely combinational.

Any opcode outside the supported set drives every output to 0. A register-format instruction with an unknown function field is treated the same way. Outputs that would otherwise be don't-care are driven to 0, so every output has one defined value for every input.

Top module: `ctl_decoder_top`

## Requirements
- R1: Opcode 000000 with function 100000 gives sel_rd_dest=1, alu_src_imm=0, load_to_reg=0, reg_wr_en=1, mem_wr_en=0, branch_eq=0, jump_abs=0, imm_sign_ext=0, alu_group=100 and alu_sel=00 (add).
- R2: Opcode 000000 with function 100010 gives the same outputs as R1 except alu_sel=01 (subtract).
- R3: Opcode 000000 with any function other than 100000 or 100010 drives every output to 0.
- R4: Opcode 001101 gives alu_src_imm=1, reg_wr_en=1, imm_sign_ext=0 (zero extension), alu_group=010 and alu_sel=10 (OR). Every other output is 0.
- R5: Opcode 100011 gives alu_src_imm=1, imm_sign_ext=1, load_to_reg=1, reg_wr_en=1, alu_group=000 and alu_sel=00. Every other output is 0.
- R6: Opcode 101011 gives alu_src_imm=1, imm_sign_ext=1, mem_wr_en=1, alu_group=000 and alu_sel=00. Every other output is 0, including reg_wr_en.
- R7: Opcode 000100 gives branch_eq=1, alu_src_imm=0, alu_group=001 and alu_sel=01. Every other output is 0.
- R8: Opcode 000010 gives jump_abs=1. Every other output is 0, including alu_group and alu_sel.
- R9: Every opcode not listed in R1 to R8 drives every output to 0.
- R10: Bits 25:6 of the instruction have no effect on any output.
- R11: At most one of reg_wr_en, mem_wr_en, branch_eq and jump_abs is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction to decode; opcode in bits 31:26, function in bits 5:0 |
| sel_rd_dest | output | 1 | 1 selects bits 15:11 as the write register, 0 selects bits 20:16 |
| alu_src_imm | output | 1 | 1 feeds the extended immediate to the second ALU input |
| load_to_reg | output | 1 | 1 writes memory read data back instead of the ALU result |
| reg_wr_en | output | 1 | Register file write enable |
| mem_wr_en | output | 1 | Data memory write enable |
| branch_eq | output | 1 | Branch on equal operands |
| jump_abs | output | 1 | Absolute jump |
| imm_sign_ext | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| alu_group | output | 3 | Group code from the main decoder to the local ALU decoder |
| alu_sel | output | 2 | Final ALU operation: 00 add, 01 subtract, 10 OR |

## Verification
The block holds no state, so a wrong decode shows at the ports in the same cycle the instruction word is presented. It cannot surface later or hide behind earlier history. The main risks are a wrong or missing truth-table row, and a function field that leaks into non-register opcodes or escapes the qualifying gate, which would leave a write enable high for an illegal instruction. For that reason the bench sweeps all 64 opcodes, checks unknown function fields, and fills the unused middle bits with random data while comparing against a clean encoding.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int GRP_W  = 3;
  localparam int ALU_W  = 2;
  localparam int WORD_W = 32;
  localparam int OP_LSB = WORD_W - OP_W;

  localparam logic [OP_W-1:0] OPC_REG = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ORI = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LDW = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STW = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JMP = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;

  localparam logic [GRP_W-1:0] GRP_REG = 3'b100;
  localparam logic [GRP_W-1:0] GRP_OR  = 3'b010;
  localparam logic [GRP_W-1:0] GRP_ADD = 3'b000;
  localparam logic [GRP_W-1:0] GRP_SUB = 3'b001;

  localparam logic [ALU_W-1:0] ALU_ADD = 2'b00;
  localparam logic [ALU_W-1:0] ALU_SUB = 2'b01;
  localparam logic [ALU_W-1:0] ALU_OR  = 2'b10;

  typedef struct packed {
    logic             dst_rd;
    logic             src_imm;
    logic             mem2reg;
    logic             reg_we;
    logic             mem_we;
    logic             br;
    logic             jmp;
    logic             sext;
    logic [GRP_W-1:0] grp;
  } main_ctl_t;

  // Main truth table: one row per supported opcode, zero row otherwise.
  function automatic main_ctl_t main_row(input logic [OP_W-1:0] op);
    main_ctl_t r;
    r = '0;
    case (op)
      OPC_REG: begin r.dst_rd = 1'b1; r.reg_we = 1'b1; r.grp = GRP_REG; end
      OPC_ORI: begin r.src_imm = 1'b1; r.reg_we = 1'b1; r.grp = GRP_OR; end
      OPC_LDW: begin
        r.src_imm = 1'b1; r.sext = 1'b1; r.mem2reg = 1'b1;
        r.reg_we = 1'b1; r.grp = GRP_ADD;
      end
      OPC_STW: begin
        r.src_imm = 1'b1; r.sext = 1'b1; r.mem_we = 1'b1; r.grp = GRP_ADD;
      end
      OPC_BEQ: begin r.br = 1'b1; r.grp = GRP_SUB; end
      OPC_JMP: begin r.jmp = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Local table: returns {known, operation}.
  function automatic logic [ALU_W:0] local_row(input logic [GRP_W-1:0] grp,
                                               input logic [FN_W-1:0] fn);
    logic [ALU_W:0] r;
    case (grp)
      GRP_REG: begin
        if (fn == FN_ADD)      r = {1'b1, ALU_ADD};
        else if (fn == FN_SUB) r = {1'b1, ALU_SUB};
        else                   r = {1'b0, ALU_ADD};
      end
      GRP_OR:  r = {1'b1, ALU_OR};
      GRP_SUB: r = {1'b1, ALU_SUB};
      default: r = {1'b1, ALU_ADD};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_dec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output main_ctl_t       ctl
);
  always_comb ctl = main_row(opcode);
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_dec_pkg::*;
(
  input  logic [GRP_W-1:0] grp,
  input  logic [FN_W-1:0]  funct,
  output logic [ALU_W-1:0] alu_op,
  output logic             fn_known
);
  logic [ALU_W:0] row;
  always_comb begin
    row      = local_row(grp, funct);
    fn_known = row[ALU_W];
    alu_op   = fn_known ? row[ALU_W-1:0] : ALU_ADD;
  end
endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
  import ctl_dec_pkg::*;
(
  input  logic [31:0] instr_word,
  output logic        sel_rd_dest,
  output logic        alu_src_imm,
  output logic        load_to_reg,
  output logic        reg_wr_en,
  output logic        mem_wr_en,
  output logic        branch_eq,
  output logic        jump_abs,
  output logic        imm_sign_ext,
  output logic [2:0]  alu_group,
  output logic [1:0]  alu_sel
);
  logic [OP_W-1:0]  op_field;
  logic [FN_W-1:0]  fn_field;
  main_ctl_t        main_ctl;
  main_ctl_t        gated_ctl;
  logic [ALU_W-1:0] local_op;
  logic             fn_known;
  logic             unused_fields;

  assign op_field      = instr_word[WORD_W-1:OP_LSB];
  assign fn_field      = instr_word[FN_W-1:0];
  assign unused_fields = ^instr_word[OP_LSB-1:FN_W];

  ctl_main_dec u_main (
    .opcode (op_field),
    .ctl    (main_ctl)
  );

  ctl_alu_dec u_alu (
    .grp      (main_ctl.grp),
    .funct    (fn_field),
    .alu_op   (local_op),
    .fn_known (fn_known)
  );

  // An unknown function field silences the whole word.
  assign gated_ctl = fn_known ? main_ctl : '0;

  assign sel_rd_dest  = gated_ctl.dst_rd;
  assign alu_src_imm  = gated_ctl.src_imm;
  assign load_to_reg  = gated_ctl.mem2reg;
  assign reg_wr_en    = gated_ctl.reg_we;
  assign mem_wr_en    = gated_ctl.mem_we;
  assign branch_eq    = gated_ctl.br;
  assign jump_abs     = gated_ctl.jmp;
  assign imm_sign_ext = gated_ctl.sext;
  assign alu_group    = gated_ctl.grp;
  assign alu_sel      = local_op;
endmodule

// File: rtl/ctl_dec_chk.sv
module ctl_dec_chk
  import ctl_dec_pkg::*;
(
  input logic [31:0] instr_word,
  input logic        sel_rd_dest,
  input logic        alu_src_imm,
  input logic        load_to_reg,
  input logic        reg_wr_en,
  input logic        mem_wr_en,
  input logic        branch_eq,
  input logic        jump_abs,
  input logic        imm_sign_ext,
  input logic [2:0]  alu_group,
  input logic [1:0]  alu_sel
);
  logic [OP_W-1:0] op;
  logic            op_known;
  logic [11:0]     all_out;

  assign op = instr_word[WORD_W-1:OP_LSB];
  assign op_known = (op == OPC_REG) || (op == OPC_ORI) || (op == OPC_LDW) ||
                    (op == OPC_STW) || (op == OPC_BEQ) || (op == OPC_JMP);
  assign all_out = {sel_rd_dest, alu_src_imm, load_to_reg, reg_wr_en, mem_wr_en,
                    branch_eq, jump_abs, imm_sign_ext, alu_group, |alu_sel};

  always_comb begin
    p_single_action_r11: assert ($onehot0({reg_wr_en, mem_wr_en, branch_eq, jump_abs}));
    p_unknown_silent_r9: assert (op_known || all_out == '0);
    p_store_sign_r6:     assert (!mem_wr_en || (imm_sign_ext && alu_src_imm && !reg_wr_en));
    p_or_zero_ext_r4:    assert (alu_sel != ALU_OR || (!imm_sign_ext && alu_src_imm && reg_wr_en));
    p_load_writes_r5:    assert (!load_to_reg || (reg_wr_en && imm_sign_ext));
    p_branch_sub_r7:     assert (!branch_eq || (alu_sel == ALU_SUB && !alu_src_imm));
    p_jump_alone_r8:     assert (!jump_abs || (alu_group == '0 && alu_sel == '0));
    p_reg_dest_r1:       assert (!sel_rd_dest || (op == OPC_REG && reg_wr_en));
  end
endmodule

bind ctl_decoder_top ctl_dec_chk u_chk (
  .instr_word   (instr_word),
  .sel_rd_dest  (sel_rd_dest),
  .alu_src_imm  (alu_src_imm),
  .load_to_reg  (load_to_reg),
  .reg_wr_en    (reg_wr_en),
  .mem_wr_en    (mem_wr_en),
  .branch_eq    (branch_eq),
  .jump_abs     (jump_abs),
  .imm_sign_ext (imm_sign_ext),
  .alu_group    (alu_group),
  .alu_sel      (alu_sel)
);

// File: tb/test_ctl_decoder_top.sv
`timescale 1ns/1ps
module test_ctl_decoder_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr;
  logic sel_rd_dest, alu_src_imm, load_to_reg, reg_wr_en, mem_wr_en;
  logic branch_eq, jump_abs, imm_sign_ext;
  logic [2:0] alu_group;
  logic [1:0] alu_sel;
  logic [12:0] got;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  ctl_decoder_top i_ctl_decoder_top (
    .instr_word(instr), .sel_rd_dest(sel_rd_dest), .alu_src_imm(alu_src_imm),
    .load_to_reg(load_to_reg), .reg_wr_en(reg_wr_en), .mem_wr_en(mem_wr_en),
    .branch_eq(branch_eq), .jump_abs(jump_abs), .imm_sign_ext(imm_sign_ext),
    .alu_group(alu_group), .alu_sel(alu_sel)
  );

  // Order: rd, imm, load, rwe, mwe, br, jmp, sext, group[2:0], alu[1:0]
  assign got = {sel_rd_dest, alu_src_imm, load_to_reg, reg_wr_en, mem_wr_en,
                branch_eq, jump_abs, imm_sign_ext, alu_group, alu_sel};

  localparam logic [12:0] E_ADD  = 13'b1_0_0_1_0_0_0_0_100_00; // R1
  localparam logic [12:0] E_SUB  = 13'b1_0_0_1_0_0_0_0_100_01; // R2
  localparam logic [12:0] E_ORI  = 13'b0_1_0_1_0_0_0_0_010_10; // R4
  localparam logic [12:0] E_LDW  = 13'b0_1_1_1_0_0_0_1_000_00; // R5
  localparam logic [12:0] E_STW  = 13'b0_1_0_0_1_0_0_1_000_00; // R6
  localparam logic [12:0] E_BEQ  = 13'b0_0_0_0_0_1_0_0_001_01; // R7
  localparam logic [12:0] E_JMP  = 13'b0_0_0_0_0_0_1_0_000_00; // R8
  localparam logic [12:0] E_ZERO = 13'b0;                      // R3, R9

  function automatic logic [12:0] expect_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'd0:  return (fn == 6'd32) ? E_ADD : (fn == 6'd34) ? E_SUB : E_ZERO;
      6'd13: return E_ORI;
      6'd35: return E_LDW;
      6'd43: return E_STW;
      6'd4:  return E_BEQ;
      6'd2:  return E_JMP;
      default: return E_ZERO;
    endcase
  endfunction

  // {instruction, expected outputs, requirement number}
  localparam int NV = 10;
  localparam logic [48:0] VEC [NV] = '{
    {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20, E_ADD,  4'd1},  // R1 add
    {6'h00, 5'd4, 5'd5, 5'd6, 5'd0, 6'h22, E_SUB,  4'd2},  // R2 subtract
    {6'h00, 5'd7, 5'd8, 5'd9, 5'd0, 6'h25, E_ZERO, 4'd3},  // R3 unknown function
    {6'h0d, 5'd1, 5'd2, 16'hffff,          E_ORI,  4'd4},  // R4 or-immediate
    {6'h23, 5'd3, 5'd4, 16'h8000,          E_LDW,  4'd5},  // R5 load
    {6'h2b, 5'd5, 5'd6, 16'h0004,          E_STW,  4'd6},  // R6 store
    {6'h04, 5'd7, 5'd7, 16'hfffe,          E_BEQ,  4'd7},  // R7 branch
    {6'h02, 26'h3ffffff,                   E_JMP,  4'd8},  // R8 jump
    {6'h3f, 26'h0000020,                   E_ZERO, 4'd9},  // R9 unknown opcode
    {6'h08, 26'h0000022,                   E_ZERO, 4'd9}   // R9 unknown opcode
  };

  task automatic check(input logic [12:0] exp, input string req);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s instr=%h got=%b exp=%b", req, instr, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  initial begin
    instr = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    check(E_ZERO, "R3 reset word");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][48:17]);
      check(VEC[i][16:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end

    // R9 with R1: every opcode against the independent table
    for (int op = 0; op < 64; op++) begin
      apply({op[5:0], 20'h12345, 6'h20});
      check(expect_of(op[5:0], 6'h20), "R9 opcode sweep");
    end

    // R3: unknown function fields on the register opcode
    for (int fn = 0; fn < 64; fn += 7) begin
      apply({6'h00, 20'h0, fn[5:0]});
      check(expect_of(6'h00, fn[5:0]), "R3 function sweep");
    end

    // R10: middle bits must not matter
    for (int k = 0; k < 24; k++) begin
      logic [5:0] ops [7];
      logic [19:0] mid;
      ops = '{6'h00, 6'h00, 6'h0d, 6'h23, 6'h2b, 6'h04, 6'h02};
      mid = 20'($urandom);
      apply({ops[k % 7], mid, (k % 7 == 1) ? 6'h22 : 6'h20});
      check(expect_of(ops[k % 7], (k % 7 == 1) ? 6'h22 : 6'h20), "R10 middle bits");
    end

    // R11: exclusive actions across the supported words
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][48:17]);
      total++;
      if ($countones({reg_wr_en, mem_wr_en, branch_eq, jump_abs}) > 1) begin
        fails++;
        $display("FAIL R11 instr=%h got=%b exp=at most one", instr,
                 {reg_wr_en, mem_wr_en, branch_eq, jump_abs});
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule